// File: doc/BRIEF.md
# Configurable Chip-Select-Gated Command Register Buffer

This block is a clocked register bank that sits on the address and command path of a memory module. On each rising clock edge it captures up to 25 data bits and two control bits, on-die termination (ODT) and clock enable (CKE), and drives them as registered outputs. Two static configuration pins choose which data bit positions are live. They also choose whether each live bit drives one output in a wide single bank, or is copied to two identical narrow banks, A and B.

A pair of active-low select inputs gates the data path. While both selects are high, the data register keeps its contents and the data outputs do not change. The ODT and CKE registers, and a registered copy of the primary select, update on every edge regardless of the selects. An active-low reset clears every register at once, without waiting for a clock.

The configuration pins are registered as well, so a change of mode shows at the outputs after the next edge. A mode change does not clear the captured data.

Top module: `cmd_regbuf`

## Requirements
- R1: When either select input is low at a rising edge, the data register takes `d_in`, and the live output positions show those bits right after that edge (one cycle of latency).
- R2: When both `rank_sel_n` and `aux_sel_n` are high at a rising edge, the data register keeps its previous contents, and no data output changes unless the mode changes.
- R3: `odt_q` and `cke_q` show `odt_in` and `cke_in` from the latest edge, whatever the selects are. The copies `odt_qa`/`odt_qb` and `cke_qa`/`cke_qb` always equal them.
- R4: `cs_q`, `cs_qa` and `cs_qb` all show `rank_sel_n` as sampled at the latest edge, whatever the selects are.
- R5: Mode {cfg_sel1,cfg_sel0}=00 is the wide mode. `q_out[p-1]` carries position p for p in 2, 3, 5, 6 and 8 to 25. Positions 1, 4 and 7 are low, and `qa_out` and `qb_out` are all low.
- R6: Mode 10 (cfg_sel1=1, cfg_sel0=0) is the narrow duplicated mode. `qa_out[j]` and `qb_out[j]` both carry position j+1 for positions 2, 3, 5, 6 and 8 to 14. All other bank bits are low, and `q_out` is all low.
- R7: Mode 11 is the sparse duplicated mode. `qa_out[j]` and `qb_out[j]` both carry position j+1 for positions 1 to 6, 8 to 10, 12 and 13. All other bank bits are low, and `q_out` is all low.
- R8: Mode 01 is reserved. In it every bit of `q_out`, `qa_out` and `qb_out` is low.
- R9: While `rst_n` is low, every output is low at once, with no clock edge needed.
- R10: A mode change takes effect at the next rising edge and keeps the captured data. Bits captured earlier appear at positions that become live, even when the selects hold the register at that edge.

`cmd_regbuf` takes two parameters: `NPOS`, the number of data positions (default 25), and `NDUP`, the width of each duplicated bank (default 14).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sel0 | input | 1 | Configuration pin, low bit of the mode |
| cfg_sel1 | input | 1 | Configuration pin, high bit of the mode |
| rank_sel_n | input | 1 | Primary active-low select, also registered to the cs outputs |
| aux_sel_n | input | 1 | Secondary active-low select |
| d_in | input | NPOS | Data bits; bit p-1 is position p |
| odt_in | input | 1 | Termination control input |
| cke_in | input | 1 | Clock-enable control input |
| q_out | output | NPOS | Wide single-bank data outputs |
| qa_out | output | NDUP | Duplicated bank A data outputs |
| qb_out | output | NDUP | Duplicated bank B data outputs |
| odt_q | output | 1 | Registered ODT |
| odt_qa | output | 1 | Registered ODT, A copy |
| odt_qb | output | 1 | Registered ODT, B copy |
| cke_q | output | 1 | Registered CKE |
| cke_qa | output | 1 | Registered CKE, A copy |
| cke_qb | output | 1 | Registered CKE, B copy |
| cs_q | output | 1 | Registered primary select |
| cs_qa | output | 1 | Registered primary select, A copy |
| cs_qb | output | 1 | Registered primary select, B copy |

## Verification
Every data, control and select result is due one rising edge after the inputs that cause it. A mode change is due at that same edge, and a reset is due at once, with no edge. The bench changes its inputs at the falling edge and updates its own model at the rising edge, using the inputs it has just applied. It compares all outputs at the next falling edge, so each check lands exactly one register stage after its stimulus. The reset checks instead sample a fraction of a nanosecond after `rst_n` falls, well before the next rising edge.

// File: rtl/regbuf_pkg.sv
`timescale 1ns/1ps
package regbuf_pkg;

  localparam int unsigned POS_MAX = 25;
  localparam int unsigned DUP_MAX = 14;

  // mode = {cfg_sel1, cfg_sel0}
  typedef enum logic [1:0] {
    MODE_WIDE   = 2'b00,
    MODE_RSVD   = 2'b01,
    MODE_DUP14  = 2'b10,
    MODE_SPARSE = 2'b11
  } mode_t;

  // live positions for a mode; bit p-1 stands for position p
  function automatic logic [POS_MAX-1:0] pos_mask(mode_t m);
    logic [POS_MAX-1:0] v;
    v = '0;
    for (int p = 1; p <= POS_MAX; p++) begin
      logic base;
      logic sparse;
      base   = (p != 1) && (p != 4) && (p != 7);
      sparse = (p <= 6) || ((p >= 8) && (p <= 10)) || (p == 12) || (p == 13);
      case (m)
        MODE_WIDE:   v[p-1] = base;
        MODE_DUP14:  v[p-1] = base && (p <= DUP_MAX);
        MODE_SPARSE: v[p-1] = sparse;
        default:     v[p-1] = 1'b0;
      endcase
    end
    return v;
  endfunction

  function automatic logic is_dual(mode_t m);
    return (m == MODE_DUP14) || (m == MODE_SPARSE);
  endfunction

  function automatic logic is_wide(mode_t m);
    return m == MODE_WIDE;
  endfunction

endpackage

// File: rtl/regbuf_cfg.sv
`timescale 1ns/1ps
module regbuf_cfg
  import regbuf_pkg::*;
#(
  parameter int unsigned NPOS = POS_MAX
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_sel0,
  input  logic            cfg_sel1,
  output logic [NPOS-1:0] mask,
  output logic            dual,
  output logic            wide
);

  mode_t mode_r;

  // the mode is registered, so a pin change shows after the next edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_r <= MODE_WIDE;
    else        mode_r <= mode_t'({cfg_sel1, cfg_sel0});
  end

  logic [POS_MAX-1:0] full_mask;

  always_comb begin
    full_mask = pos_mask(mode_r);
    dual      = is_dual(mode_r);
    wide      = is_wide(mode_r);
  end

  assign mask = full_mask[NPOS-1:0];

endmodule

// File: rtl/regbuf_cap.sv
`timescale 1ns/1ps
module regbuf_cap #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end

endmodule

// File: rtl/regbuf_fanout.sv
`timescale 1ns/1ps
module regbuf_fanout #(
  parameter int unsigned NPOS = 25,
  parameter int unsigned NDUP = 14
) (
  input  logic [NPOS-1:0] held,
  input  logic [NPOS-1:0] mask,
  input  logic            dual,
  input  logic            wide,
  output logic [NPOS-1:0] q_wide,
  output logic [NDUP-1:0] q_a,
  output logic [NDUP-1:0] q_b
);

  logic [NPOS-1:0] live;
  assign live = held & mask;

  genvar i;
  generate
    for (i = 0; i < NPOS; i++) begin : g_wide
      assign q_wide[i] = wide & live[i];
    end
    for (i = 0; i < NDUP; i++) begin : g_dup
      assign q_a[i] = dual & live[i];
      assign q_b[i] = dual & live[i];
    end
  endgenerate

endmodule

// File: rtl/cmd_regbuf.sv
`timescale 1ns/1ps
module cmd_regbuf
  import regbuf_pkg::*;
#(
  parameter int unsigned NPOS = POS_MAX,
  parameter int unsigned NDUP = DUP_MAX
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_sel0,
  input  logic            cfg_sel1,
  input  logic            rank_sel_n,
  input  logic            aux_sel_n,
  input  logic [NPOS-1:0] d_in,
  input  logic            odt_in,
  input  logic            cke_in,
  output logic [NPOS-1:0] q_out,
  output logic [NDUP-1:0] qa_out,
  output logic [NDUP-1:0] qb_out,
  output logic            odt_q,
  output logic            odt_qa,
  output logic            odt_qb,
  output logic            cke_q,
  output logic            cke_qa,
  output logic            cke_qb,
  output logic            cs_q,
  output logic            cs_qa,
  output logic            cs_qb
);

  localparam int unsigned NCTL = 3;

  // named events for the checker
  logic hold_evt;
  logic capture_evt;
  assign hold_evt    = rank_sel_n & aux_sel_n;
  assign capture_evt = ~hold_evt;

  logic [NPOS-1:0] held_q;
  logic [NCTL-1:0] ctl_q;
  logic [NPOS-1:0] mask;
  logic            dual;
  logic            wide;

  regbuf_cfg #(.NPOS(NPOS)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_sel0 (cfg_sel0),
    .cfg_sel1 (cfg_sel1),
    .mask     (mask),
    .dual     (dual),
    .wide     (wide)
  );

  regbuf_cap #(.W(NPOS)) u_data (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (capture_evt),
    .d     (d_in),
    .q     (held_q)
  );

  regbuf_cap #(.W(NCTL)) u_ctl (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (1'b1),
    .d     ({rank_sel_n, cke_in, odt_in}),
    .q     (ctl_q)
  );

  regbuf_fanout #(.NPOS(NPOS), .NDUP(NDUP)) u_fan (
    .held   (held_q),
    .mask   (mask),
    .dual   (dual),
    .wide   (wide),
    .q_wide (q_out),
    .q_a    (qa_out),
    .q_b    (qb_out)
  );

  assign odt_q  = ctl_q[0];
  assign odt_qa = ctl_q[0];
  assign odt_qb = ctl_q[0];
  assign cke_q  = ctl_q[1];
  assign cke_qa = ctl_q[1];
  assign cke_qb = ctl_q[1];
  assign cs_q   = ctl_q[2];
  assign cs_qa  = ctl_q[2];
  assign cs_qb  = ctl_q[2];

endmodule

// File: rtl/cmd_regbuf_chk.sv
`timescale 1ns/1ps
module cmd_regbuf_chk #(
  parameter int unsigned NPOS = 25,
  parameter int unsigned NDUP = 14
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_sel0,
  input logic            cfg_sel1,
  input logic            rank_sel_n,
  input logic [NPOS-1:0] d_in,
  input logic            odt_in,
  input logic            cke_in,
  input logic [NPOS-1:0] q_out,
  input logic [NDUP-1:0] qa_out,
  input logic [NDUP-1:0] qb_out,
  input logic            odt_q,
  input logic            odt_qa,
  input logic            odt_qb,
  input logic            cke_q,
  input logic            cke_qa,
  input logic            cke_qb,
  input logic            cs_q,
  input logic            cs_qa,
  input logic            cs_qb,
  input logic            hold_evt,
  input logic [NPOS-1:0] held_q
);

  assert_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_evt |=> held_q == $past(d_in));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hold_evt |=> $stable(held_q));

  assert_ctrl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (odt_q == $past(odt_in)) && (cke_q == $past(cke_in)));

  assert_copies_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (odt_qa == odt_q) && (odt_qb == odt_q) && (cke_qa == cke_q) && (cke_qb == cke_q));

  assert_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cs_q == $past(rank_sel_n)) && (cs_qa == cs_q) && (cs_qb == cs_q));

  assert_gap_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(q_out[0] || q_out[3] || q_out[6]));

  assert_bank_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (q_out != '0) |-> (qa_out == '0) && (qb_out == '0));

  assert_dup_equal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    qa_out == qb_out);

  assert_reserved_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_sel1 && cfg_sel0) |=> (q_out == '0) && (qa_out == '0) && (qb_out == '0));

endmodule

bind cmd_regbuf cmd_regbuf_chk #(.NPOS(NPOS), .NDUP(NDUP)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_sel0   (cfg_sel0),
  .cfg_sel1   (cfg_sel1),
  .rank_sel_n (rank_sel_n),
  .d_in       (d_in),
  .odt_in     (odt_in),
  .cke_in     (cke_in),
  .q_out      (q_out),
  .qa_out     (qa_out),
  .qb_out     (qb_out),
  .odt_q      (odt_q),
  .odt_qa     (odt_qa),
  .odt_qb     (odt_qb),
  .cke_q      (cke_q),
  .cke_qa     (cke_qa),
  .cke_qb     (cke_qb),
  .cs_q       (cs_q),
  .cs_qa      (cs_qa),
  .cs_qb      (cs_qb),
  .hold_evt   (hold_evt),
  .held_q     (held_q)
);

// File: tb/test_cmd_regbuf.sv
`timescale 1ns/1ps
module test_cmd_regbuf;

  localparam int NP = 25;
  localparam int ND = 14;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_sel0 = 1'b0, cfg_sel1 = 1'b0;
  logic          rank_sel_n = 1'b1, aux_sel_n = 1'b1;
  logic [NP-1:0] d_in = '0;
  logic          odt_in = 1'b0, cke_in = 1'b0;
  logic [NP-1:0] q_out;
  logic [ND-1:0] qa_out, qb_out;
  logic          odt_q, odt_qa, odt_qb, cke_q, cke_qa, cke_qb, cs_q, cs_qa, cs_qb;

  cmd_regbuf i_cmd_regbuf (
    .clk(clk), .rst_n(rst_n), .cfg_sel0(cfg_sel0), .cfg_sel1(cfg_sel1),
    .rank_sel_n(rank_sel_n), .aux_sel_n(aux_sel_n), .d_in(d_in),
    .odt_in(odt_in), .cke_in(cke_in), .q_out(q_out), .qa_out(qa_out),
    .qb_out(qb_out), .odt_q(odt_q), .odt_qa(odt_qa), .odt_qb(odt_qb),
    .cke_q(cke_q), .cke_qa(cke_qa), .cke_qb(cke_qb),
    .cs_q(cs_q), .cs_qa(cs_qa), .cs_qb(cs_qb)
  );

  always #2.5 clk = ~clk;  // 200 MHz

  int total = 0;
  int bad = 0;
  bit done = 0;

  // bench model
  logic [NP-1:0] m_held = '0;
  logic [1:0]    m_mode = 2'b00;
  logic          m_odt = 0, m_cke = 0, m_cs = 0;
  bit            m_was_hold = 0;

  function automatic bit live_pos(logic [1:0] m, int p);
    case (m)
      2'b00:   return !(p inside {1, 4, 7});
      2'b10:   return p inside {2, 3, 5, 6, [8:14]};
      2'b11:   return p inside {[1:6], [8:10], 12, 13};
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [NP-1:0] exp_wide(logic [1:0] m, logic [NP-1:0] h);
    logic [NP-1:0] r = '0;
    for (int p = 1; p <= NP; p++)
      r[p-1] = (m == 2'b00) && live_pos(m, p) && h[p-1];
    return r;
  endfunction

  function automatic logic [ND-1:0] exp_bank(logic [1:0] m, logic [NP-1:0] h);
    logic [ND-1:0] r = '0;
    for (int p = 1; p <= ND; p++)
      r[p-1] = (m[1] == 1'b1) && live_pos(m, p) && h[p-1];
    return r;
  endfunction

  function automatic string mode_tag(logic [1:0] m);
    case (m)
      2'b00:   return "R5";
      2'b10:   return "R6";
      2'b11:   return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_data(string tag);
    chk(tag, "q_out",  32'(q_out),  32'(exp_wide(m_mode, m_held)));
    chk(tag, "qa_out", 32'(qa_out), 32'(exp_bank(m_mode, m_held)));
    chk(tag, "qb_out", 32'(qb_out), 32'(exp_bank(m_mode, m_held)));
  endtask

  task automatic check_all();
    check_data(m_was_hold ? "R2" : mode_tag(m_mode));
    chk("R3", "odt", 32'({odt_q, odt_qa, odt_qb}), 32'({3{m_odt}}));
    chk("R3", "cke", 32'({cke_q, cke_qa, cke_qb}), 32'({3{m_cke}}));
    chk("R4", "cs",  32'({cs_q, cs_qa, cs_qb}),    32'({3{m_cs}}));
  endtask

  // inputs already set at the falling edge; advance one edge and update model
  task automatic step();
    @(posedge clk);
    if (rst_n) begin
      m_was_hold = rank_sel_n && aux_sel_n;
      if (!m_was_hold) m_held = d_in;
      m_mode = {cfg_sel1, cfg_sel0};
      m_odt  = odt_in;
      m_cke  = cke_in;
      m_cs   = rank_sel_n;
    end
    @(negedge clk);
  endtask

  task automatic check_zero(string tag);
    chk(tag, "reset data", 32'(q_out) | 32'(qa_out) | 32'(qb_out), 32'd0);
    chk(tag, "reset ctl",
        32'({odt_q, odt_qa, odt_qb, cke_q, cke_qa, cke_qb, cs_q, cs_qa, cs_qb}), 32'd0);
  endtask

  task automatic rand_inputs(int hold_pct);
    bit hold;
    hold = ($urandom % 100) < hold_pct;
    if (hold) begin
      rank_sel_n = 1; aux_sel_n = 1;
    end else begin
      case ($urandom % 3)
        0: begin rank_sel_n = 0; aux_sel_n = 0; end
        1: begin rank_sel_n = 0; aux_sel_n = 1; end
        default: begin rank_sel_n = 1; aux_sel_n = 0; end
      endcase
    end
    d_in   = NP'($urandom);
    odt_in = 1'($urandom);
    cke_in = 1'($urandom);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd20240611));
    // R9: reset state
    repeat (3) @(negedge clk);
    check_zero("R9");
    rst_n = 1;

    // R1: capture with one select low, each side
    cfg_sel1 = 0; cfg_sel0 = 0;
    rank_sel_n = 0; aux_sel_n = 1; d_in = 25'h1ABCDEF; odt_in = 1; cke_in = 0;
    step();
    check_data("R1");
    rank_sel_n = 1; aux_sel_n = 0; d_in = 25'h0F0F0F5; odt_in = 0; cke_in = 1;
    step();
    check_data("R1");
    check_all();

    // R2: hold keeps data while control still tracks
    rank_sel_n = 1; aux_sel_n = 1; d_in = 25'h0000000; odt_in = 1; cke_in = 1;
    step();
    check_all();

    // random phases through every mode
    for (int ph = 0; ph < 8; ph++) begin
      logic [1:0] m;
      m = 2'(ph);
      cfg_sel1 = m[1]; cfg_sel0 = m[0];
      for (int c = 0; c < 80; c++) begin
        rand_inputs(30);
        step();
        check_all();
      end
    end

    // R10: capture all ones in wide mode, then switch to sparse while held
    cfg_sel1 = 0; cfg_sel0 = 0;
    rank_sel_n = 0; aux_sel_n = 0; d_in = '1;
    step();
    check_data("R5");
    rank_sel_n = 1; aux_sel_n = 1; d_in = '0; cfg_sel1 = 1; cfg_sel0 = 1;
    step();
    check_data("R10");
    chk("R10", "qa position 1", 32'(qa_out[0]), 32'd1);
    cfg_sel1 = 1; cfg_sel0 = 0;
    step();
    check_data("R10");
    cfg_sel1 = 0; cfg_sel0 = 1;
    step();
    check_data("R8");

    // R9: asynchronous reset between edges
    cfg_sel1 = 0; cfg_sel0 = 0; rank_sel_n = 0; aux_sel_n = 0;
    d_in = '1; odt_in = 1; cke_in = 1;
    step();
    #1 rst_n = 0;
    #0.5 check_zero("R9");
    m_held = '0; m_mode = 2'b00; m_odt = 0; m_cke = 0; m_cs = 0; m_was_hold = 0;
    @(negedge clk);
    rst_n = 1;
    rand_inputs(0);
    step();
    check_all();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule